// File: doc/BRIEF.md
# Register-Window Operand Address Generator

This block sits between instruction decode and memory in a 16-bit, byte-addressed processor whose sixteen general registers are not flip-flops but a window of RAM. A bank base register places that window: register n lives at the word formed from the upper eleven bits of the base, the register number shifted up by one, and a zero in bit 0. Given a 6-bit operand specifier, the block works out where the operand is. It reports whether an extension word must follow the instruction. It also says whether the selected pointer register must be written back, and with what value.

The caller reads the pointer register from RAM beforehand and presents its value, together with the extension word if one follows. One cycle after `in_valid` the block presents the effective address, the RAM address of the register the specifier names, byte-lane write enables, the updated pointer and its write-back strobe. It also presents flags for an illegal destination and for a misaligned word access. A combinational lane stage uses the registered access width and address bit 0. It moves a byte read into the low byte of the operand and copies a byte to be written onto both lanes.

Top module: `opnd_agen`

## Requirements
- R1: `slot_addr` equals `{bank_base[15:5], n[3:0], 1'b0}` for the register n named by the specifier. In register mode (`00nnnn`) n is the field. In the pointer modes n is 8 plus the low three bits. For immediate and direct it is 0. With base 0x0100, register 14 gives 0x011C. Register mode uses `slot_addr` as the effective address and is a word access.
- R2: Decode of `opnd[5:0]`: `00nnnn` register; `011111` immediate; `10b111` direct; `01bppp` indirect through R(8+ppp); `10bppp` indirect with post-increment; `11bppp` indirect plus offset. Bit 3 (b) is 1 for byte access and 0 for word access. `need_ext` is 1 exactly for immediate, direct and offset.
- R3: Immediate used with `is_write`=1 raises `bad_dst` and asserts neither write enable. `bad_dst` is 0 in every other case.
- R4: Direct mode takes the effective address from `ext_word` and does not write back any pointer.
- R5: Indirect through R8..R14 uses `ptr_cur` as the address and leaves the pointer unchanged (`ptr_wb`=0).
- R6: Post-increment addresses `ptr_cur` and writes back `ptr_cur`+1 for a byte access or `ptr_cur`+2 for a word access, with `ptr_wb`=1.
- R7: Word indirect through R15 (`010111`) behaves as a stack. A write addresses and writes back `ptr_cur`-2. A read addresses `ptr_cur` and writes back `ptr_cur`+2. All arithmetic is modulo 2^16.
- R8: Offset mode addresses (`ptr_cur` + `ext_word`) mod 2^16, unsigned. It never writes back a pointer, R15 included.
- R9: For a word access, bit 0 of `eff_addr` is forced to 0, and `misalign` is 1 when the unforced address was odd. A byte access is never misaligned.
- R10: With `is_write`=1 and a memory or register destination, a word access raises both `wr_en_hi` and `wr_en_lo`. A byte access raises `wr_en_lo` when `eff_addr[0]`=0 and `wr_en_hi` when it is 1. A read raises neither.
- R11: For a byte access, `rd_operand` is the byte of `rd_raw` chosen by `eff_addr[0]` (1 = high byte), zero-extended. `wr_data` carries `wr_src[7:0]` on both lanes. For a word access both pass through unchanged.
- R12: `out_valid`, `ptr_wb` and the write enables rise exactly one cycle after a cycle with `in_valid`=1 and are 0 otherwise. Synchronous active-low reset clears every registered output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand request present this cycle |
| opnd | input | 6 | Operand specifier |
| is_write | input | 1 | 1 = operand is a destination |
| bank_base | input | 16 | Register window base |
| ext_word | input | 16 | Extension word after the instruction |
| ptr_cur | input | 16 | Current value of the pointer register |
| rd_raw | input | 16 | Word read from RAM at `eff_addr` |
| wr_src | input | 16 | Operand value to be stored |
| out_valid | output | 1 | Result registers hold a new answer |
| eff_addr | output | 16 | Effective operand address |
| slot_addr | output | 16 | RAM address of the named register |
| byte_acc | output | 1 | 1 = byte access |
| wr_en_hi | output | 1 | High-byte write enable |
| wr_en_lo | output | 1 | Low-byte write enable |
| ptr_next | output | 16 | Updated pointer value |
| ptr_wb | output | 1 | Write `ptr_next` to `slot_addr` |
| need_ext | output | 1 | Specifier consumes an extension word |
| bad_dst | output | 1 | Immediate used as destination |
| misalign | output | 1 | Word address was odd |
| rd_operand | output | 16 | Read operand after lane steering |
| wr_data | output | 16 | Write data after lane steering |

## Verification
Random specifiers, bank bases, pointers and extension words cover all six modes in both directions. They show whether the mode boundaries are right, the `x111` codes in particular, which are immediate or direct rather than R15. Directed cases then separate what random data rarely does. They cover the bank example, including ignored low base bits, push against pop on R15, offset wrap past 0xFFFF with R15 left alone, and odd byte post-increment against odd word indirect, which must flag misalignment. Each lane result is compared against a RAM array held in the bench, so that a swapped byte or a missing zero-extension shows up.

// File: rtl/opnd_agen_pkg.sv
// Shared widths and the addressing-mode type for the operand address generator.
// Assumes a 16-bit byte-addressed space and a 16-entry register window.
package opnd_agen_pkg;
    parameter int ADDR_W    = 16;
    parameter int SPEC_W    = 6;
    parameter int REGNUM_W  = 4;
    localparam int BANK_LSB = REGNUM_W + 1;
    localparam logic [REGNUM_W-1:0] STACK_REG = '1;

    typedef enum logic [2:0] {
        AM_REG  = 3'd0,
        AM_IMM  = 3'd1,
        AM_DIR  = 3'd2,
        AM_IND  = 3'd3,
        AM_POST = 3'd4,
        AM_OFS  = 3'd5
    } amode_e;
endpackage

// File: rtl/opnd_spec_decode.sv
// Splits a 6-bit operand specifier into addressing mode, access width and
// register number. Purely combinational; the x111 codes of the byte indirect
// and post-increment groups are taken as immediate and direct.
module opnd_spec_decode
    import opnd_agen_pkg::*;
(
    input  logic [SPEC_W-1:0]   spec,
    output amode_e              mode,
    output logic                byte_sel,
    output logic [REGNUM_W-1:0] reg_num,
    output logic                uses_reg,
    output logic                ext_used
);
    localparam logic [REGNUM_W-1:0] PTR_BASE = {1'b1, {(REGNUM_W-1){1'b0}}};

    logic [REGNUM_W-1:0] ptr_num;
    assign ptr_num = PTR_BASE | {1'b0, spec[REGNUM_W-2:0]};

    // Classify the specifier by its two top bits and the low-bit escapes.
    always_comb begin
        mode     = AM_REG;
        byte_sel = 1'b0;
        reg_num  = '0;
        unique case (spec[5:4])
            2'b00: begin
                mode    = AM_REG;
                reg_num = spec[3:0];
            end
            2'b01: begin
                if (spec[3:0] == 4'hF) begin
                    mode = AM_IMM;
                end else begin
                    mode     = AM_IND;
                    byte_sel = spec[3];
                    reg_num  = ptr_num;
                end
            end
            2'b10: begin
                byte_sel = spec[3];
                if (spec[2:0] == 3'b111) begin
                    mode = AM_DIR;
                end else begin
                    mode    = AM_POST;
                    reg_num = ptr_num;
                end
            end
            default: begin
                mode     = AM_OFS;
                byte_sel = spec[3];
                reg_num  = ptr_num;
            end
        endcase
    end

    // Flags derived from the mode.
    always_comb begin
        uses_reg = (mode != AM_IMM) && (mode != AM_DIR);
        ext_used = (mode == AM_IMM) || (mode == AM_DIR) || (mode == AM_OFS);
    end
endmodule

// File: rtl/opnd_addr_calc.sv
// Computes the raw effective address, the register slot address in the RAM
// window and the pointer update for one decoded operand. Combinational.
// Assumes ptr_val holds the register named by reg_num when a pointer mode is used.
module opnd_addr_calc
    import opnd_agen_pkg::*;
(
    input  amode_e              mode,
    input  logic                byte_sel,
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic                uses_reg,
    input  logic                is_write,
    input  logic [ADDR_W-1:0]   bank,
    input  logic [ADDR_W-1:0]   ext,
    input  logic [ADDR_W-1:0]   ptr_val,
    output logic [ADDR_W-1:0]   ea_raw,
    output logic [ADDR_W-1:0]   slot,
    output logic [ADDR_W-1:0]   ptr_upd,
    output logic                ptr_upd_en
);
    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

    logic [ADDR_W-1:0] step;
    logic              is_stack;

    // Register slot address inside the bank window.
    always_comb begin
        slot = '0;
        if (uses_reg)
            slot = {bank[ADDR_W-1:BANK_LSB], reg_num, 1'b0};
    end

    assign step     = byte_sel ? STEP_BYTE : STEP_WORD;
    assign is_stack = (reg_num == STACK_REG);

    // Mode-dependent address and pointer update.
    always_comb begin
        ea_raw     = '0;
        ptr_upd    = ptr_val;
        ptr_upd_en = 1'b0;
        unique case (mode)
            AM_REG:  ea_raw = slot;
            AM_IMM:  ea_raw = '0;
            AM_DIR:  ea_raw = ext;
            AM_IND: begin
                ea_raw = ptr_val;
                if (is_stack) begin
                    ptr_upd_en = 1'b1;
                    if (is_write) begin
                        ptr_upd = ptr_val - STEP_WORD;
                        ea_raw  = ptr_val - STEP_WORD;
                    end else begin
                        ptr_upd = ptr_val + STEP_WORD;
                    end
                end
            end
            AM_POST: begin
                ea_raw     = ptr_val;
                ptr_upd    = ptr_val + step;
                ptr_upd_en = 1'b1;
            end
            default: ea_raw = ptr_val + ext;
        endcase
    end
endmodule

// File: rtl/opnd_lane_steer.sv
// Moves data between the 16-bit RAM word and the 16-bit operand for byte and
// word accesses. Combinational; assumes word addresses are already even.
module opnd_lane_steer
    import opnd_agen_pkg::*;
(
    input  logic              byte_sel,
    input  logic              addr_lsb,
    input  logic [ADDR_W-1:0] ram_word,
    input  logic [ADDR_W-1:0] src_word,
    output logic [ADDR_W-1:0] opnd_word,
    output logic [ADDR_W-1:0] store_word
);
    localparam int HALF = ADDR_W / 2;

    // Read path: pick one byte and zero-extend, or pass the word.
    always_comb begin
        if (!byte_sel)
            opnd_word = ram_word;
        else if (addr_lsb)
            opnd_word = {{HALF{1'b0}}, ram_word[ADDR_W-1:HALF]};
        else
            opnd_word = {{HALF{1'b0}}, ram_word[HALF-1:0]};
    end

    // Write path: copy the low byte onto both lanes for a byte store.
    always_comb begin
        store_word = byte_sel ? {src_word[HALF-1:0], src_word[HALF-1:0]} : src_word;
    end
endmodule

// File: rtl/opnd_agen.sv
// Top of the operand address generator: decodes a specifier, forms the
// address and pointer update, aligns word accesses, derives lane enables and
// registers the result one cycle after in_valid. The lane steering stage
// after the register is combinational.
module opnd_agen
    import opnd_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [5:0]        opnd,
    input  logic              is_write,
    input  logic [15:0]       bank_base,
    input  logic [15:0]       ext_word,
    input  logic [15:0]       ptr_cur,
    input  logic [15:0]       rd_raw,
    input  logic [15:0]       wr_src,
    output logic              out_valid,
    output logic [15:0]       eff_addr,
    output logic [15:0]       slot_addr,
    output logic              byte_acc,
    output logic              wr_en_hi,
    output logic              wr_en_lo,
    output logic [15:0]       ptr_next,
    output logic              ptr_wb,
    output logic              need_ext,
    output logic              bad_dst,
    output logic              misalign,
    output logic [15:0]       rd_operand,
    output logic [15:0]       wr_data
);
    amode_e              d_mode;
    logic                d_byte;
    logic [REGNUM_W-1:0] d_reg;
    logic                d_uses_reg;
    logic                d_ext;
    logic [ADDR_W-1:0]   c_ea_raw;
    logic [ADDR_W-1:0]   c_slot;
    logic [ADDR_W-1:0]   c_ptr;
    logic                c_ptr_en;
    logic [ADDR_W-1:0]   n_ea;
    logic                n_mis;
    logic                n_hi;
    logic                n_lo;
    logic                n_bad;
    amode_e              mode_q;

    opnd_spec_decode u_dec (
        .spec     (opnd),
        .mode     (d_mode),
        .byte_sel (d_byte),
        .reg_num  (d_reg),
        .uses_reg (d_uses_reg),
        .ext_used (d_ext)
    );

    opnd_addr_calc u_calc (
        .mode       (d_mode),
        .byte_sel   (d_byte),
        .reg_num    (d_reg),
        .uses_reg   (d_uses_reg),
        .is_write   (is_write),
        .bank       (bank_base),
        .ext        (ext_word),
        .ptr_val    (ptr_cur),
        .ea_raw     (c_ea_raw),
        .slot       (c_slot),
        .ptr_upd    (c_ptr),
        .ptr_upd_en (c_ptr_en)
    );

    // Word alignment, destination legality and byte-lane enables.
    always_comb begin
        n_ea  = d_byte ? c_ea_raw : {c_ea_raw[ADDR_W-1:1], 1'b0};
        n_mis = !d_byte && c_ea_raw[0];
        n_bad = is_write && (d_mode == AM_IMM);
        n_hi  = 1'b0;
        n_lo  = 1'b0;
        if (is_write && (d_mode != AM_IMM)) begin
            n_hi = !d_byte || n_ea[0];
            n_lo = !d_byte || !n_ea[0];
        end
    end

    // Result register; strobes are qualified by in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            eff_addr  <= '0;
            slot_addr <= '0;
            byte_acc  <= 1'b0;
            wr_en_hi  <= 1'b0;
            wr_en_lo  <= 1'b0;
            ptr_next  <= '0;
            ptr_wb    <= 1'b0;
            need_ext  <= 1'b0;
            bad_dst   <= 1'b0;
            misalign  <= 1'b0;
            mode_q    <= AM_REG;
        end else begin
            out_valid <= in_valid;
            wr_en_hi  <= in_valid && n_hi;
            wr_en_lo  <= in_valid && n_lo;
            ptr_wb    <= in_valid && c_ptr_en;
            if (in_valid) begin
                eff_addr  <= n_ea;
                slot_addr <= c_slot;
                byte_acc  <= d_byte;
                ptr_next  <= c_ptr;
                need_ext  <= d_ext;
                bad_dst   <= n_bad;
                misalign  <= n_mis;
                mode_q    <= d_mode;
            end
        end
    end

    opnd_lane_steer u_lane (
        .byte_sel   (byte_acc),
        .addr_lsb   (eff_addr[0]),
        .ram_word   (rd_raw),
        .src_word   (wr_src),
        .opnd_word  (rd_operand),
        .store_word (wr_data)
    );

    // Result appears exactly one cycle after a request.
    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_strobes_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !ptr_wb && !wr_en_hi && !wr_en_lo);
    // A word access never reaches memory at an odd address.
    assert_word_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !byte_acc |-> !eff_addr[0]);
    // An illegal immediate destination never writes.
    assert_imm_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && bad_dst |-> !wr_en_hi && !wr_en_lo);
    // A byte store touches at most one lane.
    assert_byte_one_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && byte_acc |-> $onehot0({wr_en_hi, wr_en_lo}));
    // Post-increment always writes its pointer back; offset mode never does.
    assert_post_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == AM_POST |-> ptr_wb);
    assert_offset_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == AM_OFS |-> !ptr_wb);
endmodule

// File: tb/tb_opnd_agen.sv
// Self-checking bench: directed corner cases, then seeded random specifiers,
// all compared against a model written from the requirements.
module tb_opnd_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  opnd = '0;
    logic        is_write = 1'b0;
    logic [15:0] bank_base = '0, ext_word = '0, ptr_cur = '0, rd_raw = '0, wr_src = '0;
    logic        out_valid, byte_acc, wr_en_hi, wr_en_lo, ptr_wb, need_ext, bad_dst, misalign;
    logic [15:0] eff_addr, slot_addr, ptr_next, rd_operand, wr_data;

    int errors = 0;
    int checks = 0;
    logic [15:0] ram [64];

    always #2 clk = ~clk;

    opnd_agen dut (.*);

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected results from the requirement text.
    logic [15:0] e_ea, e_slot, e_next, e_rd, e_wd;
    logic        e_byte, e_hi, e_lo, e_wb, e_ext, e_bad, e_mis;

    task automatic model(input logic [5:0] s, input logic w, input logic [15:0] bk,
                         input logic [15:0] ex, input logic [15:0] p);
        logic [15:0] raw;
        logic [3:0]  n;
        logic        imm;
        imm    = (s == 6'b011111);
        e_byte = 1'b0; e_wb = 1'b0; e_next = p; e_slot = 16'h0; raw = 16'h0;
        e_ext  = 1'b0;
        n      = {1'b1, s[2:0]};
        if (s[5:4] == 2'b00) begin                       // R1 register
            e_slot = (bk & 16'hFFE0) | {11'h0, s[3:0], 1'b0};
            raw = e_slot;
        end else if (imm) begin                           // R2 immediate
            e_ext = 1'b1;
        end else if (s[5:4] == 2'b10 && s[2:0] == 3'b111) begin  // R4 direct
            e_ext = 1'b1; e_byte = s[3]; raw = ex;
        end else begin
            e_slot = (bk & 16'hFFE0) | {11'h0, n, 1'b0};
            e_byte = s[3];
            if (s[5:4] == 2'b01) begin
                raw = p;
                if (n == 4'hF) begin                      // R7 stack
                    e_wb = 1'b1;
                    if (w) begin raw = p - 16'd2; e_next = p - 16'd2; end
                    else   e_next = p + 16'd2;
                end
            end else if (s[5:4] == 2'b10) begin           // R6
                raw = p; e_wb = 1'b1; e_next = p + (s[3] ? 16'd1 : 16'd2);
            end else begin                                // R8
                raw = p + ex; e_ext = 1'b1;
            end
        end
        e_mis = !e_byte && raw[0];
        e_ea  = e_byte ? raw : (raw & 16'hFFFE);
        e_bad = w && imm;
        e_hi  = w && !imm && (!e_byte || e_ea[0]);
        e_lo  = w && !imm && (!e_byte || !e_ea[0]);
    endtask

    // One request: drive at a falling edge, check at the next falling edge.
    task automatic run(input logic [5:0] s, input logic w, input logic [15:0] bk,
                       input logic [15:0] ex, input logic [15:0] p, input logic [15:0] src);
        model(s, w, bk, ex, p);
        opnd = s; is_write = w; bank_base = bk; ext_word = ex; ptr_cur = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rd_raw = ram[e_ea[6:1]];
        wr_src = src;
        e_rd = e_byte ? (e_ea[0] ? {8'h0, rd_raw[15:8]} : {8'h0, rd_raw[7:0]}) : rd_raw;
        e_wd = e_byte ? {src[7:0], src[7:0]} : src;
        #1;
        chk("R12 out_valid", {15'h0, out_valid}, 16'h1);
        chk("R1 slot_addr", slot_addr, e_slot);
        chk("R2/R4/R5/R8 eff_addr", eff_addr, e_ea);
        chk("R2 byte_acc", {15'h0, byte_acc}, {15'h0, e_byte});
        chk("R2 need_ext", {15'h0, need_ext}, {15'h0, e_ext});
        chk("R3 bad_dst", {15'h0, bad_dst}, {15'h0, e_bad});
        chk("R10 wr_en", {14'h0, wr_en_hi, wr_en_lo}, {14'h0, e_hi, e_lo});
        chk("R5/R6/R7 ptr_wb", {15'h0, ptr_wb}, {15'h0, e_wb});
        if (e_wb) chk("R6/R7 ptr_next", ptr_next, e_next);
        chk("R9 misalign", {15'h0, misalign}, {15'h0, e_mis});
        chk("R11 rd_operand", rd_operand, e_rd);
        chk("R11 wr_data", wr_data, e_wd);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) ram[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset out_valid", {15'h0, out_valid}, 16'h0);
        chk("R12 reset eff_addr", eff_addr, 16'h0);
        chk("R12 reset strobes", {12'h0, ptr_wb, wr_en_hi, wr_en_lo, bad_dst}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 bank example and ignored low base bits
        run(6'b001110, 1'b0, 16'h0100, 16'h0, 16'h0, 16'h0);
        chk("R1 example 0x011C", eff_addr, 16'h011C);
        run(6'b001110, 1'b1, 16'h01FF, 16'h0, 16'h0, 16'h1234);
        chk("R1 low base bits ignored", slot_addr, 16'h01FC);
        // R3 immediate as destination
        run(6'b011111, 1'b1, 16'h0200, 16'h5555, 16'h0, 16'h0);
        chk("R3 immediate flagged", {15'h0, bad_dst}, 16'h1);
        // R4 direct byte, odd address
        run(6'b101111, 1'b0, 16'h0200, 16'h0033, 16'h0, 16'h0);
        // R5 plain indirect R10
        run(6'b010010, 1'b1, 16'h0300, 16'h0, 16'h0040, 16'hBEEF);
        // R7 push and pop through R15
        run(6'b010111, 1'b1, 16'h0100, 16'h0, 16'h0400, 16'hCAFE);
        chk("R7 push address", eff_addr, 16'h03FE);
        chk("R7 push pointer", ptr_next, 16'h03FE);
        run(6'b010111, 1'b0, 16'h0100, 16'h0, 16'h03FE, 16'h0);
        chk("R7 pop pointer", ptr_next, 16'h0400);
        // R8 offset wrap with R15, no write-back
        run(6'b110111, 1'b0, 16'h0100, 16'h0020, 16'hFFF0, 16'h0);
        chk("R8 wrap address", eff_addr, 16'h0010);
        chk("R8 R15 untouched", {15'h0, ptr_wb}, 16'h0);
        // R6 byte post-increment at odd pointer, R10 high lane
        run(6'b101001, 1'b1, 16'h0100, 16'h0, 16'h0101, 16'h00A5);
        chk("R6 byte step", ptr_next, 16'h0102);
        chk("R10 odd byte high lane", {14'h0, wr_en_hi, wr_en_lo}, 16'h2);
        // R9 odd word indirect
        run(6'b010001, 1'b0, 16'h0100, 16'h0, 16'h0023, 16'h0);
        chk("R9 forced even", eff_addr, 16'h0022);
        chk("R9 misalign raised", {15'h0, misalign}, 16'h1);
        // R11 byte read of high lane
        run(6'b011000, 1'b0, 16'h0100, 16'h0, 16'h0007, 16'h0);
        chk("R11 high byte zero-extended", rd_operand[15:8], 16'h0);
        // Random mix
        for (int k = 0; k < 400; k++)
            run(6'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom));
        // R12 idle cycle after a request
        @(negedge clk);
        chk("R12 idle out_valid", {15'h0, out_valid}, 16'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule